// File: doc/BRIEF.md
# Down-Counting Timer with Toggle Output

This block is a 16-bit down-counter driven from a byte-wide register port. Software loads a 16-bit reload value one byte at a time and starts the counter through a control register. While it runs, the counter steps down by one on every clock. Each pass through zero reloads it from the reload value and raises a one-clock interrupt request.

An optional toggle mode gives the timer ownership of an output pin, and the pin inverts on every underflow. When software reloads and starts the counter, the pin does not move. When toggle mode is switched off, the pin keeps the level the timer left on it and becomes an ordinary data-driven output.

A capture input copies the live count on its rising edge. Software reads a 16-bit value by reading its low byte first. That read also loads the matching high byte into a single shared latch, so the two bytes always come from the same clock cycle. The latch can be read at two addresses.

Top module: `dectimer_top`

## Requirements
- R1: After reset the count, the reload value, the capture value, the high-byte latch and the pin are all zero, tmrIrq is low, and every control bit reads as 0.
- R2: While running, the count drops by one per clock. On the clock after the count is zero it reloads from the reload value, so one period is reload+1 clocks. A write to address 0 sets the reload low byte, and a write to address 1 sets the reload high byte.
- R3: A write to the control register (address 4) with bit0=1 loads the count from the reload value and starts it, and leaves the pin unchanged. A write to the control register takes priority over an underflow in the same cycle.
- R4: With control bit1 (toggle enable) set, the pin inverts on every underflow.
- R5: When control bit2 (interrupt enable) is set, tmrIrq is high for exactly the one clock that follows each underflow. Toggling does not depend on bit2.
- R6: A high idleIn stops neither counting nor toggling.
- R7: Clearing bit1 leaves the pin at the last level the timer drove. After that, writes to address 5 drive the pin from bit0.
- R8: While bit1 is set, writes to address 5 do not change the pin.
- R9: A read of address 5 returns the pin level in bit0, with zeros in the bits above it.
- R10: A read of address 0 returns the count low byte and loads the latch with the count high byte from the same cycle. A read of address 2 returns the capture low byte and loads the latch with the capture high byte. Nothing else changes the latch.
- R11: The latch reads back at both address 1 and address 3, with the same value at each.
- R12: A rising edge on captureIn copies the count into the capture register and does not alter the count sequence.
- R13: Control reads return running in bit0, toggle enable in bit1 and interrupt enable in bit2. A control write with bit0=0 stops the counter and holds the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 3 | Register address |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Register read strobe; has side effects on the latch |
| rdData | output | 8 | Read data for regSel, combinational |
| captureIn | input | 1 | Capture trigger, acts on its rising edge |
| idleIn | input | 1 | Device idle indication |
| tmrIrq | output | 1 | One-clock interrupt request after an underflow |
| pinOut | output | 1 | Timer output pin |

## Verification
The counter is run with a small reload (period 4), with reload 0 (an underflow on every clock) and with a large reload, 0x1234, whose high byte stays stable while the low byte counts. These separate an off-by-one in the period from a missed reload and from a latch loaded at the wrong moment. Toggle mode is tried with the interrupt off and on, with idle held high, and with port writes aimed at the pin, which shows whether toggling is truly independent of those inputs. Starting and disabling are each applied while the pin is high and while it is low, so a start that toggles the pin or a disable that glitches it shows at once. A capture pulse taken in the middle of a count is then read back through both latch addresses.

// File: rtl/dectimer_pkg.sv
package dectimer_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_CNT_LO = 3'd0,
    A_HI_A   = 3'd1,
    A_CAP_LO = 3'd2,
    A_HI_B   = 3'd3,
    A_CTRL   = 3'd4,
    A_PORT   = 3'd5
  } regAddr_e;

  typedef struct packed {
    logic loadCount;
    logic decCount;
    logic underflow;
    logic toggle;
    logic capture;
    logic latchCnt;
    logic latchCap;
    logic wrRelLo;
    logic wrRelHi;
    logic wrPort;
  } ctlStrb_t;
endpackage

// File: rtl/dectimer_ctrl.sv
module dectimer_ctrl
  import dectimer_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regSel,
  input  logic                  wrEn,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic                  rdEn,
  input  logic                  captureIn,
  input  logic                  idleIn,
  input  logic                  countZero,
  output ctlStrb_t              strb,
  output logic                  running,
  output logic                  toggleEn,
  output logic                  irqEn,
  output logic                  tmrIrq
);
  localparam int unsigned RUN_BIT = 0;
  localparam int unsigned TOG_BIT = 1;
  localparam int unsigned IRQ_BIT = 2;

  logic ctrlWr;
  logic startWr;
  logic capPrev;

  assign ctrlWr  = wrEn && (regSel == A_CTRL);
  assign startWr = ctrlWr && wrData[RUN_BIT];

  always_comb begin
    strb           = '0;
    strb.underflow = running && countZero && !ctrlWr;
    strb.loadCount = startWr || strb.underflow;
    strb.decCount  = running && !countZero && !ctrlWr;
    strb.toggle    = strb.underflow && toggleEn;
    strb.capture   = captureIn && !capPrev;
    strb.latchCnt  = rdEn && (regSel == A_CNT_LO);
    strb.latchCap  = rdEn && (regSel == A_CAP_LO);
    strb.wrRelLo   = wrEn && (regSel == A_CNT_LO);
    strb.wrRelHi   = wrEn && (regSel == A_HI_A);
    strb.wrPort    = wrEn && (regSel == A_PORT) && !toggleEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      toggleEn <= 1'b0;
      irqEn    <= 1'b0;
      capPrev  <= 1'b0;
      tmrIrq   <= 1'b0;
    end else begin
      capPrev <= captureIn;
      tmrIrq  <= strb.underflow && irqEn;
      if (ctrlWr) begin
        running  <= wrData[RUN_BIT];
        toggleEn <= wrData[TOG_BIT];
        irqEn    <= wrData[IRQ_BIT];
      end
    end
  end

  // R5: a request only ever follows an underflow with the enable set
  assert_irq_follows_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    tmrIrq |-> ($past(strb.underflow) && $past(irqEn)));

  // R6: idle never holds the counter back
  assert_idle_keeps_counting_R6: assert property (@(posedge clk) disable iff (!rstN)
    (idleIn && running && !countZero && !wrEn) |-> strb.decCount);

  // R13: a stop write leaves the timer not running
  assert_stop_clears_run_R13: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[RUN_BIT]) |=> !running);
endmodule

// File: rtl/dectimer_dp.sv
module dectimer_dp
  import dectimer_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrb_t            strb,
  input  logic [BYTE_W-1:0]   wrData,
  output logic [2*BYTE_W-1:0] count,
  output logic [2*BYTE_W-1:0] capVal,
  output logic [BYTE_W-1:0]   hiLatch,
  output logic                pinLevel,
  output logic                countZero
);
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned LANES  = CNT_W / BYTE_W;

  logic [BYTE_W-1:0] relLane [LANES];
  logic [LANES-1:0]  relLaneWr;
  logic [CNT_W-1:0]  reloadVal;

  assign relLaneWr = {strb.wrRelHi, strb.wrRelLo};

  for (genvar lane = 0; lane < LANES; lane++) begin : g_relLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                relLane[lane] <= '0;
      else if (relLaneWr[lane]) relLane[lane] <= wrData;
    end
    assign reloadVal[lane*BYTE_W +: BYTE_W] = relLane[lane];
  end

  assign countZero = (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      capVal   <= '0;
      hiLatch  <= '0;
      pinLevel <= 1'b0;
    end else begin
      if (strb.loadCount)     count <= reloadVal;
      else if (strb.decCount) count <= count - 1'b1;

      if (strb.capture) capVal <= count;

      if (strb.latchCnt)      hiLatch <= count[CNT_W-1:BYTE_W];
      else if (strb.latchCap) hiLatch <= capVal[CNT_W-1:BYTE_W];

      if (strb.toggle)      pinLevel <= ~pinLevel;
      else if (strb.wrPort) pinLevel <= wrData[0];
    end
  end

  // R2: an underflow lands the reload value in the counter
  assert_underflow_reload_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.underflow |=> (count == $past(reloadVal)));

  // R2: a plain step removes exactly one
  assert_dec_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decCount && !strb.loadCount) |=> (count == $past(count) - 1'b1));

  // R4: a toggle strobe flips the pin
  assert_toggle_flips_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.toggle |=> (pinLevel != $past(pinLevel)));

  // R10: the latch moves only on a low-byte read
  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.latchCnt && !strb.latchCap) |=> $stable(hiLatch));

  // R12: capture leaves the counting path alone
  assert_capture_no_disturb_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.loadCount && !strb.decCount) |=> $stable(count));
endmodule

// File: rtl/dectimer_top.sv
module dectimer_top
  import dectimer_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regSel,
  input  logic                  wrEn,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic                  rdEn,
  output logic [BYTE_W-1:0]     rdData,
  input  logic                  captureIn,
  input  logic                  idleIn,
  output logic                  tmrIrq,
  output logic                  pinOut
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  ctlStrb_t          strb;
  logic              running;
  logic              toggleEn;
  logic              irqEn;
  logic              countZero;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  capVal;
  logic [BYTE_W-1:0] hiLatch;
  logic              pinLevel;

  dectimer_ctrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .captureIn(captureIn), .idleIn(idleIn), .countZero(countZero),
    .strb(strb), .running(running), .toggleEn(toggleEn), .irqEn(irqEn),
    .tmrIrq(tmrIrq)
  );

  dectimer_dp #(.BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .count(count),
    .capVal(capVal), .hiLatch(hiLatch), .pinLevel(pinLevel), .countZero(countZero)
  );

  assign pinOut = pinLevel;

  always_comb begin
    rdData = '0;
    case (regSel)
      A_CNT_LO:       rdData = count[BYTE_W-1:0];
      A_HI_A, A_HI_B: rdData = hiLatch;
      A_CAP_LO:       rdData = capVal[BYTE_W-1:0];
      A_CTRL:         rdData[2:0] = {irqEn, toggleEn, running};
      A_PORT:         rdData[0] = pinLevel;
      default:        rdData = '0;
    endcase
  end

  // R3: a start write never moves the pin
  assert_start_keeps_pin_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (regSel == A_CTRL) && wrData[0]) |=> $stable(pinOut));

  // R8: port writes are shut out while the timer owns the pin
  assert_port_write_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (toggleEn && wrEn && (regSel == A_PORT) && !strb.toggle) |=> $stable(pinOut));

  // R7: switching toggle mode off leaves the pin where it was
  assert_disable_holds_pin_R7: assert property (@(posedge clk) disable iff (!rstN)
    (toggleEn && wrEn && (regSel == A_CTRL) && !wrData[1]) |=> $stable(pinOut));
endmodule

// File: tb/dectimer_tb.sv
module dectimer_top_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] rgSel = '0;
  logic       wE = 1'b0;
  logic [7:0] wD = '0;
  logic       rE = 1'b0;
  logic [7:0] rdData;
  logic       capIn = 1'b0;
  logic       idle = 1'b0;
  logic       tmrIrq;
  logic       pinOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  int mCount, mReload, mCap, mLatch, mPin, mRun, mTog, mIrqEn, mIrq, mCapPrev;

  always #(CLK_P/2) clk = ~clk;

  dectimer_top dut_i (
    .clk(clk), .rstN(rstN), .regSel(rgSel), .wrEn(wE), .wrData(wD), .rdEn(rE),
    .rdData(rdData), .captureIn(capIn), .idleIn(idle), .tmrIrq(tmrIrq), .pinOut(pinOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int oc, ot, oie, orun, und;
    if (!rstN) begin
      mCount = 0; mReload = 0; mCap = 0; mLatch = 0; mPin = 0;
      mRun = 0; mTog = 0; mIrqEn = 0; mIrq = 0; mCapPrev = 0;
    end else begin
      oc = mCount; ot = mTog; oie = mIrqEn; orun = mRun; und = 0;
      if (rE && rgSel == 0) mLatch = (oc >> 8) & 255;
      if (rE && rgSel == 2) mLatch = (mCap >> 8) & 255;
      if (capIn && !mCapPrev) mCap = oc;
      mCapPrev = capIn;
      if (wE && rgSel == 4) begin
        mIrqEn = wD[2]; mTog = wD[1]; mRun = wD[0];
        if (wD[0]) mCount = mReload;
      end else if (orun != 0) begin
        if (oc == 0) begin und = 1; mCount = mReload; end
        else mCount = oc - 1;
      end
      if (wE && rgSel == 0) mReload = (mReload & 'hFF00) | int'(wD);
      if (wE && rgSel == 1) mReload = (mReload & 'hFF) | (int'(wD) << 8);
      if (und != 0 && ot != 0) mPin = mPin ^ 1;
      else if (wE && rgSel == 5 && ot == 0) mPin = wD[0];
      mIrq = (und != 0 && oie != 0) ? 1 : 0;
    end
  end

  // per-clock comparison of outputs (R4 pin, R5 request)
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(pinOut == mPin[0], "R4 pin vs model", int'(pinOut), mPin);
      chk(tmrIrq == mIrq[0], "R5 irq vs model", int'(tmrIrq), mIrq);
    end
  end

  function automatic int expRead(input int a);
    case (a)
      0: return mCount & 255;
      1, 3: return mLatch;
      2: return mCap & 255;
      4: return mIrqEn * 4 + mTog * 2 + mRun;
      5: return mPin;
      default: return 0;
    endcase
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    rgSel = a[2:0]; wD = d[7:0]; wE = 1'b1;
    @(negedge clk);
    wE = 1'b0;
  endtask

  task automatic rd(input int a, input string tag, output int got);
    @(negedge clk);
    rgSel = a[2:0]; rE = 1'b1;
    #1;
    got = int'(rdData);
    chk(got == expRead(a), tag, got, expRead(a));
    @(negedge clk);
    rE = 1'b0;
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, v2, p, flips, irqs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(pinOut == 1'b0, "R1 pin after reset", int'(pinOut), 0);
    chk(tmrIrq == 1'b0, "R1 irq after reset", int'(tmrIrq), 0);
    rd(4, "R1 control after reset", v);
    chk(v == 0, "R1 control zero", v, 0);
    rd(1, "R1 latch after reset", v);
    chk(v == 0, "R1 latch zero", v, 0);

    // R2 period with reload 3, R3 start does not toggle, R4 toggling, irq off
    wr(0, 3); wr(1, 0);
    p = int'(pinOut);
    wr(4, 3);
    chk(int'(pinOut) == p, "R3 start keeps pin", int'(pinOut), p);
    rd(4, "R13 control reads run+toggle", v);
    chk(v == 3, "R13 control value", v, 3);
    flips = 0; irqs = 0;
    for (int i = 0; i < 40; i++) begin
      p = int'(pinOut);
      @(negedge clk);
      if (int'(pinOut) != p) flips++;
      if (tmrIrq) irqs++;
    end
    chk(flips == 10, "R2 R4 ten toggles in 40 clocks", flips, 10);
    chk(irqs == 0, "R5 no irq while disabled", irqs, 0);
    rd(0, "R2 count low", v);

    // R5 interrupt on, toggles continue
    wr(4, 7);
    irqs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tmrIrq) irqs++;
    end
    chk(irqs == 10, "R5 ten one-clock requests", irqs, 10);

    // R6 idle high keeps toggling
    idle = 1'b1;
    flips = 0;
    for (int i = 0; i < 40; i++) begin
      p = int'(pinOut);
      @(negedge clk);
      if (int'(pinOut) != p) flips++;
    end
    chk(flips == 10, "R6 toggles during idle", flips, 10);
    idle = 1'b0;

    // R3 restart while pin in either level
    for (int k = 0; k < 2; k++) begin
      idleCycles(k + 1);
      p = int'(pinOut);
      wr(4, 3);
      chk(int'(pinOut) == p, "R3 restart keeps pin", int'(pinOut), p);
    end

    // R8 port writes ignored in toggle mode (timer stopped, toggle on)
    wr(4, 2);
    p = int'(pinOut);
    wr(5, p ^ 1);
    chk(int'(pinOut) == p, "R8 port write ignored", int'(pinOut), p);
    rd(5, "R9 port read returns pin", v);
    chk(v == p, "R9 pin level", v, p);

    // R7 disable while running, at two different levels
    for (int k = 0; k < 2; k++) begin
      wr(4, 3);
      idleCycles(2 + k * 4);
      p = int'(pinOut);
      wr(4, 0);
      chk(int'(pinOut) == p, "R7 disable holds pin", int'(pinOut), p);
      wr(5, p ^ 1);
      chk(int'(pinOut) == (p ^ 1), "R7 port drives pin after disable", int'(pinOut), p ^ 1);
      rd(5, "R9 port read after port write", v);
    end

    // R13 stop holds count
    wr(0, 9); wr(1, 0);
    wr(4, 1);
    idleCycles(3);
    wr(4, 0);
    rd(0, "R13 stopped count", v);
    idleCycles(5);
    rd(0, "R13 count held", v2);
    chk(v2 == v, "R13 count unchanged while stopped", v2, v);

    // R10 R11 coherent read of 0x1234 and down
    wr(0, 'h34); wr(1, 'h12);
    wr(4, 1);
    idleCycles(4);
    rd(0, "R10 count low read", v);
    rd(1, "R11 latch at address 1", v);
    chk(v == 'h12, "R10 latch holds count high", v, 'h12);
    rd(3, "R11 latch at address 3", v2);
    chk(v2 == v, "R11 aliases agree", v2, v);

    // R12 capture mid-count
    @(negedge clk); capIn = 1'b1;
    @(negedge clk); capIn = 1'b0;
    idleCycles(3);
    rd(2, "R12 capture low", v);
    rd(3, "R12 capture high via latch", v);
    chk(v == 'h12, "R12 capture high byte", v, 'h12);
    rd(0, "R12 count continues", v);

    // R2 reload 0: underflow every clock
    wr(0, 0); wr(1, 0);
    wr(4, 3);
    flips = 0;
    for (int i = 0; i < 10; i++) begin
      p = int'(pinOut);
      @(negedge clk);
      if (int'(pinOut) != p) flips++;
    end
    chk(flips == 10, "R2 reload zero toggles every clock", flips, 10);
    wr(4, 0);

    idleCycles(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule